// File: doc/BRIEF.md
# Gated Pulse Accumulator

This peripheral keeps a 16-bit tally driven by one external input pin. Software sets it up through a small register bus with four addresses. In event mode, each selected edge of the pin adds one to the tally. In gated mode, the tally advances once every 64 system clocks for as long as the pin stays at the chosen level. In that mode the edge that closes the gate raises the input flag.

Two sticky flags record a wrap of the tally and the selected pin edge. Each flag has its own interrupt enable. A flag is cleared by writing 1 to it. When the fast-clear input is high, any bus access to a tally byte clears both flags instead. The block also produces a tick for an external timer counter. That tick comes from the outside prescaler, from the pin's rising edges directly, or from the pin's rising edges divided down.

Top module: `pulse_tally`

## Requirements
- R1: After reset, all of the following read as zero: the control register (address 0), the status register (address 1), the tally and both interrupt outputs. Bit 7 of the control read is always 0. Control bits: 6 enable, 5 gated mode, 4 edge select, 3:2 timer clock select, 1 wrap interrupt enable, 0 edge interrupt enable. Status bits: 1 wrap flag, 0 edge flag. A read of address 2 returns the full 16-bit tally, and a write to it loads the high byte. Address 3 reads and writes the low byte. Reads return 0 when `bus_rd` is low.
- R2: With enable at 0, pin activity changes neither the tally nor the flags.
- R3: In event mode, edge select 1 counts rising edges and 0 counts falling edges. The pin passes through two synchronizer stages, so the tally changes on the third rising clock edge after the pin changes.
- R4: In gated mode, the tally gains one per 64 clocks while the pin is high (edge select 0) or low (edge select 1), and it holds while the pin is at the other level.
- R5: The edge flag is set by the falling edge when edge select is 0, and by the rising edge when it is 1, in both modes. In gated mode this is the edge that ends the gate.
- R6: `irq_ovf` is high exactly when the wrap flag and its enable are both 1. `irq_edge` is high exactly when the edge flag and its enable are both 1.
- R7: An increment from 0xFFFF leaves the tally at 0x0000 and sets the wrap flag.
- R8: With fast clear off, writing status clears each flag whose data bit is 1 and leaves the other flag unchanged.
- R9: With `fast_clr_en` high, a read or write of address 2 or 3 clears both flags. A flag set in that same cycle stays set.
- R10: A write to a tally byte loads that byte. In that cycle the increment is dropped.
- R11: Timer clock select 00 passes `presc_tick`. Select 01 gives one tick per pin rising edge. Select 10 gives one tick per 256 rising edges, and select 11 gives one tick per 65536 rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data, valid while `bus_rd` is high |
| pin_in | input | 1 | Asynchronous accumulator input pin |
| fast_clr_en | input | 1 | Tally access clears the flags when high |
| presc_tick | input | 1 | Tick from the normal timer prescaler |
| tmr_tick | output | 1 | Selected timer-counter tick |
| irq_ovf | output | 1 | Wrap interrupt request |
| irq_edge | output | 1 | Pin edge interrupt request |

## Verification
Two pairs of events can fall in the same clock. The first pair is a flag being set and a fast-clear access. The second pair is a tally increment and a bus load of the tally. The bench provokes each pair by changing the pin and counting two clock edges through the synchronizer, then holding the bus access across the third edge, which is the edge where the synchronized event lands. The results are judged at the ports. The edge flag must still read 1 after the fast-clear read. The low byte must hold the written value, not that value plus one.

// File: rtl/pt_pkg.sv
package pt_pkg;

   typedef enum logic [1:0] {
      ADDR_CTRL   = 2'd0,
      ADDR_STAT   = 2'd1,
      ADDR_CNT_HI = 2'd2,
      ADDR_CNT_LO = 2'd3
   } pt_addr_e;

   typedef enum logic [1:0] {
      TCLK_PRESC = 2'd0,
      TCLK_PIN   = 2'd1,
      TCLK_DIV_A = 2'd2,
      TCLK_DIV_B = 2'd3
   } pt_tclk_e;

   typedef struct packed {
      logic     en;
      logic     gated;
      logic     edge_hi;
      pt_tclk_e clk_sel;
      logic     ovf_ie;
      logic     edge_ie;
   } pt_ctrl_t;

   localparam int CTRL_W = $bits(pt_ctrl_t);

endpackage

// File: rtl/pt_pin_sync.sv
module pt_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic lvl,
   output logic rise,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pt_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= pin_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign lvl  = chain_q[STAGES-1];
   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;
endmodule

// File: rtl/pt_gate_div.sv
module pt_gate_div #(
   parameter int DIV_LOG2 = 6
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV_LOG2 < 1 || DIV_LOG2 > 16) begin : g_bad_div
         $error("pt_gate_div: DIV_LOG2 out of range");
      end
   endgenerate

   logic [DIV_LOG2-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   assign tick = &div_q;
endmodule

// File: rtl/pt_accum.sv
module pt_accum #(
   parameter int BYTE_W = 8,
   localparam int CNT_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              ld_hi,
   input  logic              ld_lo,
   input  logic [BYTE_W-1:0] wdata,
   output logic [CNT_W-1:0]  cnt,
   output logic              wrap
);
   logic [BYTE_W-1:0] hi_q, lo_q;
   logic              any_ld;
   logic [CNT_W-1:0]  cnt_plus;

   assign any_ld   = ld_hi | ld_lo;
   assign cnt      = {hi_q, lo_q};
   assign cnt_plus = cnt + 1'b1;
   assign wrap     = inc & ~any_ld & (&cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (any_ld) begin
         if (ld_hi) hi_q <= wdata;
         if (ld_lo) lo_q <= wdata;
      end else if (inc) begin
         hi_q <= cnt_plus[CNT_W-1:BYTE_W];
         lo_q <= cnt_plus[BYTE_W-1:0];
      end
   end
endmodule

// File: rtl/pt_tclk_sel.sv
module pt_tclk_sel
   import pt_pkg::*;
#(
   parameter int PRE_A_LOG2 = 8,
   parameter int PRE_B_LOG2 = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     pin_rise,
   input  logic     presc_tick,
   input  pt_tclk_e sel,
   output logic     tick
);
   generate
      if (PRE_A_LOG2 < 1 || PRE_B_LOG2 <= PRE_A_LOG2) begin : g_bad_pre
         $error("pt_tclk_sel: need 1 <= PRE_A_LOG2 < PRE_B_LOG2");
      end
   endgenerate

   logic [PRE_B_LOG2-1:0] pre_q;
   logic                  tick_a, tick_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pre_q <= '0;
      else if (pin_rise) pre_q <= pre_q + 1'b1;
   end

   assign tick_a = pin_rise & (&pre_q[PRE_A_LOG2-1:0]);
   assign tick_b = pin_rise & (&pre_q);

   always_comb begin
      unique case (sel)
         TCLK_PRESC: tick = presc_tick;
         TCLK_PIN:   tick = pin_rise;
         TCLK_DIV_A: tick = tick_a;
         TCLK_DIV_B: tick = tick_b;
         default:    tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/pulse_tally.sv
module pulse_tally
   import pt_pkg::*;
#(
   parameter int BYTE_W        = 8,
   parameter int SYNC_STAGES   = 2,
   parameter int GATE_DIV_LOG2 = 6,
   parameter int PRE_A_LOG2    = 8,
   parameter int PRE_B_LOG2    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [2*BYTE_W-1:0] bus_rdata,
   input  logic              pin_in,
   input  logic              fast_clr_en,
   input  logic              presc_tick,
   output logic              tmr_tick,
   output logic              irq_ovf,
   output logic              irq_edge
);
   localparam int CNT_W = 2 * BYTE_W;

   generate
      if (BYTE_W < CTRL_W + 1) begin : g_bad_byte
         $error("pulse_tally: BYTE_W too small for control register");
      end
   endgenerate

   pt_ctrl_t          ctrl_q;
   logic              ovf_q, edge_q;
   logic              pin_lvl, pin_rise, pin_fall;
   logic              gate_tick;
   logic              cnt_inc, ld_hi, ld_lo, cnt_wrap;
   logic [CNT_W-1:0]  cnt_q;
   logic              ev_edge, gate_open;
   logic              edge_set, ovf_set;
   logic              cnt_access, fclr;
   logic [1:0]        w1c;
   pt_addr_e          addr;

   assign addr = pt_addr_e'(bus_addr);

   pt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (pin_in),
      .lvl       (pin_lvl),
      .rise      (pin_rise),
      .fall      (pin_fall)
   );

   pt_gate_div #(.DIV_LOG2(GATE_DIV_LOG2)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (gate_tick)
   );

   // Selected edge: same edge counts in event mode and ends the gate in gated mode
   assign ev_edge   = ctrl_q.edge_hi ? pin_rise : pin_fall;
   assign gate_open = gate_tick & (pin_lvl ^ ctrl_q.edge_hi);
   assign cnt_inc   = ctrl_q.en & (ctrl_q.gated ? gate_open : ev_edge);

   assign ld_hi = bus_wr & (addr == ADDR_CNT_HI);
   assign ld_lo = bus_wr & (addr == ADDR_CNT_LO);

   pt_accum #(.BYTE_W(BYTE_W)) u_accum (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc),
      .ld_hi (ld_hi),
      .ld_lo (ld_lo),
      .wdata (bus_wdata),
      .cnt   (cnt_q),
      .wrap  (cnt_wrap)
   );

   pt_tclk_sel #(.PRE_A_LOG2(PRE_A_LOG2), .PRE_B_LOG2(PRE_B_LOG2)) u_tclk (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_rise   (pin_rise),
      .presc_tick (presc_tick),
      .sel        (ctrl_q.clk_sel),
      .tick       (tmr_tick)
   );

   // Control register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (bus_wr && addr == ADDR_CTRL)
         ctrl_q <= pt_ctrl_t'(bus_wdata[CTRL_W-1:0]);
   end

   // Flags: a set in the same cycle beats any clear
   assign edge_set   = ctrl_q.en & ev_edge;
   assign ovf_set    = cnt_wrap;
   assign cnt_access = (bus_wr | bus_rd) & bus_addr[1];
   assign fclr       = fast_clr_en & cnt_access;
   assign w1c        = (bus_wr && addr == ADDR_STAT) ? bus_wdata[1:0] : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q  <= 1'b0;
         edge_q <= 1'b0;
      end else begin
         ovf_q  <= ovf_set  | (ovf_q  & ~fclr & ~w1c[1]);
         edge_q <= edge_set | (edge_q & ~fclr & ~w1c[0]);
      end
   end

   assign irq_ovf  = ovf_q  & ctrl_q.ovf_ie;
   assign irq_edge = edge_q & ctrl_q.edge_ie;

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         unique case (addr)
            ADDR_CTRL:   bus_rdata[CTRL_W-1:0] = ctrl_q;
            ADDR_STAT:   bus_rdata[1:0]        = {ovf_q, edge_q};
            ADDR_CNT_HI: bus_rdata             = cnt_q;
            ADDR_CNT_LO: bus_rdata[BYTE_W-1:0] = cnt_q[BYTE_W-1:0];
            default:     bus_rdata             = '0;
         endcase
      end
   end
endmodule

// File: rtl/pulse_tally_chk.sv
module pulse_tally_chk #(
   parameter int BYTE_W = 8,
   localparam int CNT_W = 2 * BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [6:0]        ctrl,
   input logic [CNT_W-1:0]  cnt,
   input logic              inc,
   input logic              ld_hi,
   input logic              ld_lo,
   input logic [BYTE_W-1:0] wdata,
   input logic              ovf_q,
   input logic              edge_q,
   input logic              ovf_set,
   input logic              edge_set,
   input logic              fclr,
   input logic              rd,
   input logic [1:0]        addr,
   input logic [CNT_W-1:0]  rdata
);
   // R1: control read never shows anything above bit 6
   p_ctrl_msb_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && addr == 2'd0) |-> (rdata[CNT_W-1:7] == '0));

   // R2: a disabled accumulator holds its tally without bus loads
   p_disabled_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[6] && !ld_hi && !ld_lo) |=> $stable(cnt));

   // R7: increment from all ones raises the wrap flag
   p_rollover_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld_hi && !ld_lo && cnt == '1) |=> (ovf_q && cnt == '0));

   // R9: fast clear with no new event empties both flags
   p_fast_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fclr && !ovf_set && !edge_set) |=> (!ovf_q && !edge_q));

   // R9: a new edge event survives a simultaneous clear
   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      edge_set |=> edge_q);

   // R10: a low-byte load wins over a concurrent increment
   p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ld_lo |=> (cnt[BYTE_W-1:0] == $past(wdata)));
endmodule

bind pulse_tally pulse_tally_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctrl     (ctrl_q),
   .cnt      (cnt_q),
   .inc      (cnt_inc),
   .ld_hi    (ld_hi),
   .ld_lo    (ld_lo),
   .wdata    (bus_wdata),
   .ovf_q    (ovf_q),
   .edge_q   (edge_q),
   .ovf_set  (ovf_set),
   .edge_set (edge_set),
   .fclr     (fclr),
   .rd       (bus_rd),
   .addr     (bus_addr),
   .rdata    (bus_rdata)
);

// File: tb/sim_pulse_tally.sv
`timescale 1ns/1ps
module sim_pulse_tally;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [7:0]  bus_wdata = 8'd0;
   logic [15:0] bus_rdata;
   logic        pin_in = 1'b0, fast_clr_en = 1'b0, presc_tick = 1'b0;
   logic        tmr_tick, irq_ovf, irq_edge;

   int n_run = 0, n_fail = 0;
   int tick_cnt = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pulse_tally u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .fast_clr_en(fast_clr_en), .presc_tick(presc_tick),
      .tmr_tick(tmr_tick), .irq_ovf(irq_ovf), .irq_edge(irq_edge)
   );

   always @(negedge clk) if (tmr_tick) tick_cnt++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // clocked read: the access is seen by the design at the next edge
   task automatic rd(input logic [1:0] a, output int v);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output int v);
      bus_rd = 1'b1; bus_addr = a;
      #1 v = bus_rdata;
      bus_rd = 1'b0;
      #1;
   endtask

   task automatic toggle(input int n);
      for (int i = 0; i < n; i++) begin
         pin_in = 1'b1; cycles(4);
         pin_in = 1'b0; cycles(4);
      end
   endtask

   task automatic t_reset;
      int v;
      rd(2'd0, v); chk_eq("R1 ctrl", v, 0);
      rd(2'd1, v); chk_eq("R1 status", v, 0);
      rd(2'd2, v); chk_eq("R1 tally", v, 0);
      chk_eq("R1 irqs", {irq_ovf, irq_edge}, 0);
      wr(2'd0, 8'hFF);
      rd(2'd0, v); chk_eq("R1 ctrl bit7", v, 8'h7F);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_disabled;
      int v;
      toggle(3); cycles(4);
      rd(2'd2, v); chk_eq("R2 tally", v, 0);
      rd(2'd1, v); chk_eq("R2 flags", v, 0);
   endtask

   task automatic t_event;
      int v;
      wr(2'd0, 8'h50);
      toggle(5); cycles(4);
      rd(2'd2, v); chk_eq("R3 rising count", v, 5);
      rd(2'd1, v); chk_eq("R5 rise flag", v, 1);
      chk_eq("R6 edge irq masked", irq_edge, 0);
      // latency through the synchronizer
      @(negedge clk); pin_in = 1'b1;
      @(negedge clk); @(negedge clk);
      peek(2'd2, v); chk_eq("R3 not yet after two edges", v, 5);
      @(negedge clk);
      peek(2'd2, v); chk_eq("R3 counted on third edge", v, 6);
      pin_in = 1'b0; cycles(4);
      wr(2'd1, 8'h03);
      rd(2'd1, v); chk_eq("R8 cleared", v, 0);
      wr(2'd0, 8'h41);
      wr(2'd2, 8'h00); wr(2'd3, 8'h00);
      toggle(4); cycles(4);
      rd(2'd2, v); chk_eq("R3 falling count", v, 4);
      chk_eq("R6 edge irq", irq_edge, 1);
   endtask

   task automatic t_overflow;
      int v;
      wr(2'd0, 8'h42);
      wr(2'd2, 8'hFF); wr(2'd3, 8'hFE);
      wr(2'd1, 8'h03);
      toggle(2); cycles(4);
      rd(2'd2, v); chk_eq("R7 wrapped tally", v, 0);
      rd(2'd1, v); chk_eq("R7 wrap flag", v, 3);
      chk_eq("R6 wrap irq", irq_ovf, 1);
      wr(2'd1, 8'h01);
      rd(2'd1, v); chk_eq("R8 only edge cleared", v, 2);
      wr(2'd1, 8'h02);
      rd(2'd1, v); chk_eq("R8 wrap cleared", v, 0);
      chk_eq("R6 irq dropped", irq_ovf, 0);
   endtask

   task automatic t_gated;
      int v, base;
      wr(2'd0, 8'h60);
      wr(2'd2, 8'h00); wr(2'd3, 8'h00); wr(2'd1, 8'h03);
      pin_in = 1'b1; cycles(640);
      pin_in = 1'b0; cycles(8);
      rd(2'd2, v); chk(v >= 9 && v <= 11, "R4 high gate", v, 10);
      base = v;
      rd(2'd1, v); chk_eq("R5 trailing fall flag", v, 1);
      cycles(640);
      rd(2'd2, v); chk_eq("R4 closed gate holds", v, base);
      wr(2'd0, 8'h70);
      wr(2'd2, 8'h00); wr(2'd3, 8'h00); wr(2'd1, 8'h03);
      cycles(640);
      rd(2'd1, v); chk_eq("R5 no flag while gate open", v, 0);
      pin_in = 1'b1; cycles(8);
      rd(2'd2, v); chk(v >= 9 && v <= 11, "R4 low gate", v, 10);
      rd(2'd1, v); chk_eq("R5 trailing rise flag", v, 1);
      pin_in = 1'b0; cycles(4);
   endtask

   task automatic t_fast_clear;
      int v;
      wr(2'd0, 8'h50);
      wr(2'd1, 8'h03);
      toggle(1); cycles(4);
      fast_clr_en = 1'b1;
      rd(2'd3, v);
      rd(2'd1, v); chk_eq("R9 fast clear", v, 0);
      // edge event and fast-clear access in the same cycle
      @(negedge clk); pin_in = 1'b1;
      @(negedge clk); @(negedge clk);
      bus_rd = 1'b1; bus_addr = 2'd3;
      @(negedge clk); bus_rd = 1'b0;
      rd(2'd1, v); chk_eq("R9 set beats clear", v, 1);
      fast_clr_en = 1'b0;
      pin_in = 1'b0; cycles(4);
   endtask

   task automatic t_write_prio;
      int v;
      wr(2'd2, 8'h00); wr(2'd3, 8'h10);
      @(negedge clk); pin_in = 1'b1;
      @(negedge clk); @(negedge clk);
      bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h55;
      @(negedge clk); bus_wr = 1'b0;
      rd(2'd2, v); chk_eq("R10 load wins", v, 16'h0055);
      pin_in = 1'b0; cycles(4);
      toggle(1); cycles(4);
      rd(2'd2, v); chk_eq("R10 counts after load", v, 16'h0056);
   endtask

   task automatic t_clksel;
      wr(2'd0, 8'h54); cycles(2);
      tick_cnt = 0; toggle(10); cycles(4);
      chk_eq("R11 pin clock", tick_cnt, 10);
      wr(2'd0, 8'h58); cycles(2);
      tick_cnt = 0; toggle(256); cycles(4);
      chk_eq("R11 pin clock / 256", tick_cnt, 1);
      wr(2'd0, 8'h50); cycles(2);
      tick_cnt = 0;
      @(negedge clk); presc_tick = 1'b1; cycles(5); presc_tick = 1'b0;
      toggle(3); cycles(4);
      chk_eq("R11 prescaler clock", tick_cnt, 5);
   endtask

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(2);
      t_reset();
      t_disabled();
      t_event();
      t_overflow();
      t_gated();
      t_fast_clear();
      t_write_prio();
      t_clksel();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule